// File: doc/BRIEF.md
# Byte Read-Modify-Write and Stack Swap Sequencer

This block performs one memory-side operation per start pulse on a byte-wide memory that answers reads one clock after they are issued. Four of the operations work on the single byte addressed by a 16-bit pointer: add one, subtract one, clear a chosen bit, or set a chosen bit. The fifth operation swaps a 16-bit register pair with the little-endian word held at a stack address.

Each clock is one T-state. Every operation lasts a fixed number of T-states. The cycles left over once the memory traffic is finished are spent waiting, so `done` marks the last T-state of the budget exactly. At that point the sequencer reports the new register pair value, a zero indication for add and subtract, and the number of T-states the operation used. A host core drives the pointer, stack address and register pair value together with the operation code, pulses `start`, and picks up the results when `done` is high.

Top module: `rmw_seq`

## Requirements
- R1: Operation code 0 reads the byte at `ptr`, adds one modulo 256 (0xFF becomes 0x00) and writes the result back to `ptr`. The operation takes 11 T-states.
- R2: Operation code 1 reads the byte at `ptr`, subtracts one modulo 256 (0x00 becomes 0xFF) and writes the result back. The operation takes 11 T-states.
- R3: Operation code 2 clears bit `bit_sel` of the byte at `ptr` and writes the byte back with every other bit unchanged. The operation takes 15 T-states.
- R4: Operation code 3 sets bit `bit_sel` of the byte at `ptr` and writes the byte back with every other bit unchanged. The operation takes 15 T-states.
- R5: Operation code 4 reads the byte at `sp` as the low byte and the byte at `sp`+1 as the high byte. It writes `pair_in[7:0]` to `sp` and `pair_in[15:8]` to `sp`+1. When `done` is high, `pair_out` equals {byte read at `sp`+1, byte read at `sp`}. The operation takes 19 T-states.
- R6: The second address of the swap is computed modulo 2^16, so `sp` = 0xFFFF pairs with address 0x0000.
- R7: The start edge counts as T-state 1. `done` is high for exactly one cycle, on the T-state that equals the operation's budget. At that point `tstate_cnt` equals the budget, and it keeps that value after `done` falls until the next operation starts.
- R8: A memory read returns its data in the cycle after `mem_rd`. A write is issued only after that data has been captured. Each single-byte operation makes exactly one write and the swap makes exactly two. `mem_rd` and `mem_wr` are never high together.
- R9: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands and its timing, and no second operation starts when the first one finishes.
- R10: After an add or subtract, `zero_flag` is 1 when the written byte is 0x00 and 0 otherwise.
- R11: A `start` with an operation code of 5, 6 or 7 is ignored. `busy` stays low and no memory access occurs.
- R12: After synchronous reset, `busy`, `done`, `mem_rd`, `mem_wr`, `zero_flag`, `pair_out` and `tstate_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op_sel | input | 3 | Operation code (0 add, 1 subtract, 2 clear bit, 3 set bit, 4 swap) |
| bit_sel | input | 3 | Bit index for clear/set |
| ptr | input | 16 | Byte address for single-byte operations |
| sp | input | 16 | Stack address for the swap |
| pair_in | input | 16 | Register pair value written by the swap |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last T-state of the operation |
| pair_out | output | 16 | Register pair value taken from the stack |
| zero_flag | output | 1 | Add/subtract result was zero |
| tstate_cnt | output | 5 | T-states used by the current or last operation |

## Verification
The start edge is the first T-state, so `done` must be seen after exactly 11, 15 or 19 clock edges. The bench counts edges from the start edge and compares that count with the budget, rather than waiting for `done` and checking only the data. The memory contents, `zero_flag` and `pair_out` are sampled in the falling-edge half of the `done` cycle, when every write has been committed. One further half-cycle later the bench checks that `done` has dropped and that `tstate_cnt` has held its value. For ignored starts, the bench keeps counting to the first operation's budget and confirms that no second operation started and no byte at the second address changed.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int BSEL_W = $clog2(DATA_W);
    localparam int PAIR_W = 2 * DATA_W;

    typedef enum logic [2:0] {
        OP_INC = 3'd0,
        OP_DEC = 3'd1,
        OP_RES = 3'd2,
        OP_SET = 3'd3,
        OP_XCH = 3'd4
    } rmw_op_e;

    typedef enum logic [2:0] {
        PH_WAIT,
        PH_RD_LO,
        PH_CAP_LO,
        PH_RD_HI,
        PH_CAP_HI,
        PH_WR_LO,
        PH_WR_HI
    } rmw_phase_e;

    typedef struct packed {
        rmw_op_e             op;
        logic [BSEL_W-1:0]   bsel;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W-1:0]   sp;
        logic [PAIR_W-1:0]   pair;
    } rmw_cmd_t;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic [DATA_W-1:0] bit_mask(input logic [BSEL_W-1:0] b);
        return DATA_W'(1) << b;
    endfunction

    function automatic logic is_arith(input rmw_op_e op);
        return (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
(
    input  rmw_op_e             op,
    input  logic [BSEL_W-1:0]   bsel,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic                zero
);

    logic [DATA_W-1:0] mask;

    always_comb begin
        mask = bit_mask(bsel);
        case (op)
            OP_INC:  dout = din + DATA_W'(1);
            OP_DEC:  dout = din - DATA_W'(1);
            OP_RES:  dout = din & ~mask;
            OP_SET:  dout = din | mask;
            default: dout = din;
        endcase
        zero = (dout == '0);
    end

endmodule

// File: rtl/rmw_timer.sv
module rmw_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [TW-1:0] budget,
    output logic          busy,
    output logic [TW-1:0] tcnt,
    output logic          done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tcnt <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy <= 1'b1;
                tcnt <= TW'(1);
            end
        end else if (tcnt == budget) begin
            busy <= 1'b0;
        end else begin
            tcnt <= tcnt + TW'(1);
        end
    end

    assign done = busy && (tcnt == budget);

    // R7
    done_ends_op_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && $stable(tcnt)));

    // R7
    tcnt_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tcnt != '0 && tcnt <= budget));

    // R7
    tcnt_steps_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (tcnt == $past(tcnt) + TW'(1)));

endmodule

// File: rtl/rmw_port.sv
module rmw_port
    import rmw_pkg::*;
#(
    parameter int TW = 5
) (
    input  rmw_cmd_t            cmd,
    input  logic                busy,
    input  logic [TW-1:0]       tcnt,
    input  logic [DATA_W-1:0]   mod_byte,
    output rmw_phase_e          phase,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [DATA_W-1:0]   mem_wdata
);

    logic [ADDR_W-1:0] sp_next;
    logic              swap;

    assign swap    = (cmd.op == OP_XCH);
    assign sp_next = cmd.sp + ADDR_W'(1);

    always_comb begin
        phase = PH_WAIT;
        if (busy) begin
            if (swap) begin
                case (tcnt)
                    TW'(1):  phase = PH_RD_LO;
                    TW'(2):  phase = PH_RD_HI;
                    TW'(3):  phase = PH_CAP_HI;
                    TW'(4):  phase = PH_WR_LO;
                    TW'(5):  phase = PH_WR_HI;
                    default: phase = PH_WAIT;
                endcase
            end else begin
                case (tcnt)
                    TW'(1):  phase = PH_RD_LO;
                    TW'(2):  phase = PH_CAP_LO;
                    TW'(3):  phase = PH_WR_LO;
                    default: phase = PH_WAIT;
                endcase
            end
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        case (phase)
            PH_RD_LO: begin
                mem_rd   = 1'b1;
                mem_addr = swap ? cmd.sp : cmd.ptr;
            end
            PH_RD_HI: begin
                mem_rd   = 1'b1;
                mem_addr = sp_next;
            end
            PH_WR_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = swap ? cmd.sp : cmd.ptr;
                mem_wdata = swap ? cmd.pair[DATA_W-1:0] : mod_byte;
            end
            PH_WR_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_next;
                mem_wdata = cmd.pair[PAIR_W-1:DATA_W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
#(
    parameter int T_ARITH = 11,
    parameter int T_BITOP = 15,
    parameter int T_SWAP  = 19,
    parameter int TW      = $clog2(T_SWAP + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          op_sel,
    input  logic [BSEL_W-1:0]   bit_sel,
    input  logic [ADDR_W-1:0]   ptr,
    input  logic [ADDR_W-1:0]   sp,
    input  logic [PAIR_W-1:0]   pair_in,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                busy,
    output logic                done,
    output logic [PAIR_W-1:0]   pair_out,
    output logic                zero_flag,
    output logic [TW-1:0]       tstate_cnt
);

    rmw_cmd_t          cmd_q;
    rmw_phase_e        phase;
    logic              accept;
    logic [TW-1:0]     budget;
    logic [TW-1:0]     tcnt;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] lo_q;
    logic [PAIR_W-1:0] pair_q;
    logic              zero_q;
    logic              got_data;
    logic [DATA_W-1:0] alu_out;
    logic              alu_zero;

    assign accept = start && !busy && op_legal(op_sel);

    always_comb begin
        case (cmd_q.op)
            OP_INC, OP_DEC: budget = TW'(T_ARITH);
            OP_RES, OP_SET: budget = TW'(T_BITOP);
            default:        budget = TW'(T_SWAP);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q.op   <= rmw_op_e'(op_sel);
            cmd_q.bsel <= bit_sel;
            cmd_q.ptr  <= ptr;
            cmd_q.sp   <= sp;
            cmd_q.pair <= pair_in;
        end
    end

    rmw_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .launch (accept),
        .budget (budget),
        .busy   (busy),
        .tcnt   (tcnt),
        .done   (done)
    );

    rmw_alu u_alu (
        .op   (cmd_q.op),
        .bsel (cmd_q.bsel),
        .din  (data_q),
        .dout (alu_out),
        .zero (alu_zero)
    );

    rmw_port #(.TW(TW)) u_port (
        .cmd       (cmd_q),
        .busy      (busy),
        .tcnt      (tcnt),
        .mod_byte  (alu_out),
        .phase     (phase),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            lo_q     <= '0;
            pair_q   <= '0;
            zero_q   <= 1'b0;
            got_data <= 1'b0;
        end else begin
            if (accept) begin
                got_data <= 1'b0;
            end
            case (phase)
                PH_CAP_LO: begin
                    data_q   <= mem_rdata;
                    got_data <= 1'b1;
                end
                PH_RD_HI: begin
                    lo_q     <= mem_rdata;
                    got_data <= 1'b1;
                end
                PH_CAP_HI: pair_q <= {mem_rdata, lo_q};
                PH_WR_LO: begin
                    if (is_arith(cmd_q.op)) begin
                        zero_q <= alu_zero;
                    end
                end
                default: ;
            endcase
        end
    end

    assign pair_out   = pair_q;
    assign zero_flag  = zero_q;
    assign tstate_cnt = tcnt;

    // R8
    wr_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> got_data);

    // R8
    rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    // R8
    capture_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAP_LO || phase == PH_CAP_HI) |-> $past(mem_rd));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(cmd_q));

    // R11
    bad_op_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op_sel > 3'd4) |=> !busy);

    // R6
    hi_addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WR_HI) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R1
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && cmd_q.op == OP_INC && data_q == '1) |-> (mem_wdata == '0));

    // R2
    dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && cmd_q.op == OP_DEC && data_q == '0) |-> (mem_wdata == '1));

    // R3
    res_keeps_others_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && cmd_q.op == OP_RES) |->
            (((mem_wdata ^ data_q) & ~bit_mask(cmd_q.bsel)) == '0 && !mem_wdata[cmd_q.bsel]));

    // R4
    set_keeps_others_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && cmd_q.op == OP_SET) |->
            (((mem_wdata ^ data_q) & ~bit_mask(cmd_q.bsel)) == '0 && mem_wdata[cmd_q.bsel]));

endmodule

// File: tb/sim_rmw_seq.sv
module sim_rmw_seq;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  bsel;
        logic [15:0] addr;
        logic [15:0] pair;
        logic [7:0]  ilo;
        logic [7:0]  ihi;
        logic [7:0]  elo;
        logic [7:0]  ehi;
        logic [15:0] epair;
        logic        ez;
        logic [4:0]  cyc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 3'd0, 16'h0010, 16'h0000, 8'h7F, 8'h11, 8'h80, 8'h11, 16'h0000, 1'b0, 5'd11},
        '{3'd0, 3'd0, 16'h0020, 16'h0000, 8'hFF, 8'h22, 8'h00, 8'h22, 16'h0000, 1'b1, 5'd11},
        '{3'd1, 3'd0, 16'h0030, 16'h0000, 8'h00, 8'h33, 8'hFF, 8'h33, 16'h0000, 1'b0, 5'd11},
        '{3'd1, 3'd0, 16'h0040, 16'h0000, 8'h01, 8'h44, 8'h00, 8'h44, 16'h0000, 1'b1, 5'd11},
        '{3'd2, 3'd5, 16'h0050, 16'h0000, 8'hFF, 8'h55, 8'hDF, 8'h55, 16'h0000, 1'b0, 5'd15},
        '{3'd2, 3'd0, 16'h0060, 16'h0000, 8'h01, 8'h66, 8'h00, 8'h66, 16'h0000, 1'b0, 5'd15},
        '{3'd3, 3'd0, 16'h0070, 16'h0000, 8'h00, 8'h77, 8'h01, 8'h77, 16'h0000, 1'b0, 5'd15},
        '{3'd3, 3'd7, 16'h0080, 16'h0000, 8'h55, 8'h88, 8'hD5, 8'h88, 16'h0000, 1'b0, 5'd15},
        '{3'd4, 3'd0, 16'h0090, 16'hABCD, 8'h34, 8'h12, 8'hCD, 8'hAB, 16'h1234, 1'b0, 5'd19},
        '{3'd4, 3'd0, 16'hFFFF, 16'h5AA5, 8'h78, 8'h56, 8'hA5, 8'h5A, 16'h5678, 1'b0, 5'd19}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [2:0]  bit_sel = '0;
    logic [15:0] ptr = '0;
    logic [15:0] sp = '0;
    logic [15:0] pair_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        busy;
    logic        done;
    logic [15:0] pair_out;
    logic        zero_flag;
    logic [4:0]  tstate_cnt;

    logic [7:0]  mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_a = '0;
    logic [7:0]  ld_d = '0;
    int          wr_total = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    rmw_seq u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_sel     (op_sel),
        .bit_sel    (bit_sel),
        .ptr        (ptr),
        .sp         (sp),
        .pair_in    (pair_in),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .done       (done),
        .pair_out   (pair_out),
        .zero_flag  (zero_flag),
        .tstate_cnt (tstate_cnt)
    );

    always @(posedge clk) begin
        if (ld_en) begin
            mem[ld_a] <= ld_d;
        end else if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_total <= wr_total + 1;
        end
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        ld_en = 1'b1;
        ld_a  = a[7:0];
        ld_d  = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic string req_of(input vec_t v);
        case (v.op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            default: return (v.addr == 16'hFFFF) ? "R6" : "R5";
        endcase
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        chk("R12", "busy", busy, 0);
        chk("R12", "done", done, 0);
        chk("R12", "rd/wr", {mem_rd, mem_wr}, 0);
        chk("R12", "tstate_cnt", tstate_cnt, 0);
        chk("R12", "pair_out", pair_out, 0);
        chk("R12", "zero_flag", zero_flag, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t        v;
            logic [15:0] a_hi;
            int          n;
            int          w0;
            string       rq;
            v    = VECS[i];
            rq   = req_of(v);
            a_hi = v.addr + 16'd1;
            poke(v.addr, v.ilo);
            poke(a_hi, v.ihi);
            w0      = wr_total;
            op_sel  = v.op;
            bit_sel = v.bsel;
            ptr     = v.addr;
            sp      = v.addr;
            pair_in = v.pair;
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n = 1;
            while (!done && n < 40) begin
                @(negedge clk);
                n++;
            end
            chk(rq, "done T-state (R7)", n, v.cyc);
            chk(rq, "tstate_cnt at done (R7)", tstate_cnt, v.cyc);
            chk(rq, "byte at addr", mem[v.addr[7:0]], v.elo);
            chk(rq, "byte at addr+1", mem[a_hi[7:0]], v.ehi);
            chk("R8", "write count", wr_total - w0, (v.op == 3'd4) ? 2 : 1);
            if (v.op <= 3'd1) chk("R10", "zero_flag", zero_flag, v.ez);
            if (v.op == 3'd4) chk(rq, "pair_out", pair_out, v.epair);
            @(negedge clk);
            chk("R7", "done one cycle", {busy, done}, 0);
            chk("R7", "tstate_cnt held", tstate_cnt, v.cyc);
        end

        // R9: second start while busy is ignored
        begin
            int n;
            poke(16'h00A0, 8'h10);
            poke(16'h00B0, 8'h00);
            op_sel = 3'd0; bit_sel = 3'd0; ptr = 16'h00A0; sp = 16'h00A0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n = 1;
            while (!done && n < 40) begin
                if (n == 3) begin
                    op_sel = 3'd3; bit_sel = 3'd1; ptr = 16'h00B0;
                    start = 1'b1;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                n++;
            end
            start = 1'b0;
            chk("R9", "done T-state", n, 11);
            chk("R9", "first target", mem[8'hA0], 8'h11);
            chk("R9", "ignored target", mem[8'hB0], 8'h00);
            @(negedge clk);
            chk("R9", "no second op", busy, 0);
        end

        // R11: undefined operation code ignored
        begin
            int w0;
            w0 = wr_total;
            op_sel = 3'd6; ptr = 16'h00C0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R11", "busy", busy, 0);
            repeat (20) @(negedge clk);
            chk("R11", "writes", wr_total - w0, 0);
            chk("R11", "done", done, 0);
        end

        finish_run();
    end

endmodule